// File: doc/BRIEF.md
# Dual-Buffer Page Flash Sequencer

This block is the core of a paged flash memory behind a simple parallel command port. The main array is a parameterised on-chip memory that is organised as pages of bytes. A host loads bytes into one of two page-sized staging buffers. It then orders a self-timed commit, which first clears a chosen page and then writes that page from the buffer. While a commit is using one buffer, the host can keep filling or reading the other one, so the two buffers work in ping-pong.

The block also erases a single page or an aligned group of eight pages. It can copy a page into a buffer, so one byte can be changed in three steps: copy, modify, write back. It also streams the array as one continuous byte sequence that runs across page boundaries. The output `ready` is low while an internal operation runs. A write-protect input blocks every command that would alter the array. Serial shifting, opcode decoding and real cell timing are left to the surrounding logic.

Top module: `dbuf_flash_seq`

## Requirements
- R1: Pages hold PAGE_BYTES bytes, indexed 0 to PAGE_BYTES-1. A command whose byte index is PAGE_BYTES or more, or whose page index is PAGES or more, is rejected and changes nothing. Any command except NOP (op 0) and read-next (op 8) is checked this way.
- R2: Op 1 writes `cmd_wdata` into buffer `cmd_buf` at byte `cmd_byte`. Op 2 reads that location and returns it on `rd_data`, with `rd_valid` high, in the cycle after acceptance. The two buffers are independent, and `rd_valid` and `cmd_reject` are never high together.
- R3: While an operation that uses a buffer (op 3 or op 6) is running, the other buffer accepts reads and writes. An access to the buffer in use is rejected and leaves that buffer unchanged.
- R4: Op 3 replaces every byte of page `cmd_page` with the contents of buffer `cmd_buf`, whatever the page held before. It needs no separate erase command.
- R5: Op 4 sets every byte of page `cmd_page` to 0xFF. Op 5 sets pages 8n to 8n+7 to 0xFF, where n is `cmd_page`/8. Pages outside the target keep their data.
- R6: `ready` is low from the cycle after an accepted op 3, 4, 5 or 6 until the operation ends, and is high otherwise. The busy time is 2*PAGE_BYTES+OP_CYCLES cycles for op 3, PAGE_BYTES+OP_CYCLES for op 4, 8*PAGE_BYTES+OP_CYCLES for op 5 and PAGE_BYTES for op 6.
- R7: Op 6 copies page `cmd_page` into buffer `cmd_buf`. After that copy, a change to one buffer byte followed by op 3 alters only that byte of the page.
- R8: Op 7 returns the array byte at (`cmd_page`, `cmd_byte`). Each op 8 returns the next byte. After the last byte of a page comes byte 0 of the next page, and after the last byte of page PAGES-1 comes page 0 byte 0.
- R9: While `write_protect` is high, ops 3, 4 and 5 are rejected and the array is left unchanged. Buffer accesses still work.
- R10: While `ready` is low, ops 3 to 8 are rejected: `cmd_reject` pulses in the next cycle and neither the array nor the read position changes.
- R11: After reset, `ready` is high, `rd_valid` and `cmd_reject` are low, and every array and buffer byte reads 0xFF.

Op codes 9 to 15 are rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 4 | Command code, 0 to 8 |
| cmd_buf | input | 1 | Buffer select |
| cmd_page | input | $clog2(PAGES) | Page index (for op 5, any page of the block) |
| cmd_byte | input | $clog2(PAGE_BYTES) | Byte index within a page or buffer |
| cmd_wdata | input | 8 | Byte for buffer write |
| write_protect | input | 1 | High blocks array-altering commands |
| ready | output | 1 | High when no internal operation runs |
| cmd_reject | output | 1 | Pulse: previous command was refused |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 8 | Read byte |

## Verification
The assertions assume a few things about the inputs: `cmd_op` is steady and meaningful whenever `cmd_valid` is high, and `write_protect` changes only between commands. The stimulus drives every command shortly after a falling edge and drops `cmd_valid` just after the edge that takes the command. It changes `write_protect` only while no command is pending, so every property sees one clean command per accepting edge. Commands issued during a busy window are limited to a dozen or so cycles. That keeps them well inside the shortest program window and inside no transfer window.

// File: rtl/fsq_pkg.sv
package fsq_pkg;

  typedef enum logic [3:0] {
    OP_NOP       = 4'd0,
    OP_BUF_WR    = 4'd1,
    OP_BUF_RD    = 4'd2,
    OP_PROG      = 4'd3,
    OP_PG_ERASE  = 4'd4,
    OP_BLK_ERASE = 4'd5,
    OP_PG_TO_BUF = 4'd6,
    OP_RD_START  = 4'd7,
    OP_RD_NEXT   = 4'd8
  } fsq_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ERASE,
    ST_PROG,
    ST_XFER,
    ST_SETTLE
  } fsq_state_e;

  // linear array index of a (page, byte) pair
  function automatic int unsigned flat_index(int unsigned pg, int unsigned bi,
                                             int unsigned pb);
    return pg * pb + bi;
  endfunction

  // first page of the aligned group that holds pg
  function automatic int unsigned block_first(int unsigned pg, int unsigned grp);
    return (pg / grp) * grp;
  endfunction

  function automatic int unsigned step_byte(int unsigned bi, int unsigned pb);
    return (bi + 1 == pb) ? 0 : bi + 1;
  endfunction

  function automatic int unsigned step_page(int unsigned pg, int unsigned bi,
                                            int unsigned pb, int unsigned pages);
    if (bi + 1 != pb) return pg;
    return (pg + 1 == pages) ? 0 : pg + 1;
  endfunction

  function automatic logic alters_array(fsq_op_e op);
    return (op == OP_PROG) || (op == OP_PG_ERASE) || (op == OP_BLK_ERASE);
  endfunction

  function automatic logic needs_idle(fsq_op_e op);
    return alters_array(op) || (op == OP_PG_TO_BUF) ||
           (op == OP_RD_START) || (op == OP_RD_NEXT);
  endfunction

  function automatic logic is_buf_op(fsq_op_e op);
    return (op == OP_BUF_WR) || (op == OP_BUF_RD);
  endfunction

endpackage

// File: rtl/fsq_sram.sv
module fsq_sram #(
  parameter int DEPTH = 264,
  parameter int AW    = $clog2(DEPTH),
  parameter logic [7:0] INIT = 8'hFF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= INIT;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/fsq_seq.sv
module fsq_seq
  import fsq_pkg::*;
#(
  parameter int PAGES      = 16,
  parameter int PAGE_BYTES = 264,
  parameter int BLK_PAGES  = 8,
  parameter int OP_CYCLES  = 16,
  parameter int PW         = $clog2(PAGES),
  parameter int BW         = $clog2(PAGE_BYTES),
  parameter int AW         = $clog2(PAGES * PAGE_BYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  fsq_op_e       start_op,
  input  logic [PW-1:0] start_page,
  input  logic          start_buf,
  input  logic [7:0]    buf_rdata,
  input  logic [7:0]    arr_rdata,
  output logic          busy,
  output logic          buf_lock,
  output logic          act_buf,
  output logic          arr_we,
  output logic [AW-1:0] arr_addr,
  output logic [7:0]    arr_wdata,
  output logic          buf_we,
  output logic [BW-1:0] buf_idx,
  output logic [7:0]    buf_wdata,
  output logic          ev_done
);

  localparam int CW = $clog2(BLK_PAGES * PAGE_BYTES);
  localparam int SW = $clog2(OP_CYCLES + 1);

  fsq_state_e    state;
  logic [AW-1:0] base;
  logic [CW-1:0] cnt, last;
  logic [SW-1:0] scnt;
  logic          then_prog, uses_buf;
  logic          at_last;

  assign at_last = (cnt == last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      base      <= '0;
      cnt       <= '0;
      last      <= '0;
      scnt      <= '0;
      then_prog <= 1'b0;
      uses_buf  <= 1'b0;
      act_buf   <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          cnt       <= '0;
          last      <= CW'(PAGE_BYTES - 1);
          base      <= AW'(flat_index(32'(start_page), 0, PAGE_BYTES));
          then_prog <= (start_op == OP_PROG);
          uses_buf  <= (start_op == OP_PROG) || (start_op == OP_PG_TO_BUF);
          act_buf   <= start_buf;
          case (start_op)
            OP_PROG, OP_PG_ERASE: state <= ST_ERASE;
            OP_BLK_ERASE: begin
              state <= ST_ERASE;
              last  <= CW'(BLK_PAGES * PAGE_BYTES - 1);
              base  <= AW'(flat_index(block_first(32'(start_page), BLK_PAGES),
                                      0, PAGE_BYTES));
            end
            OP_PG_TO_BUF: state <= ST_XFER;
            default:      state <= ST_IDLE;
          endcase
        end
        ST_ERASE: begin
          if (at_last) begin
            cnt <= '0;
            if (then_prog) begin
              state <= ST_PROG;
            end else begin
              state <= ST_SETTLE;
              scnt  <= SW'(OP_CYCLES - 1);
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_PROG: begin
          if (at_last) begin
            state <= ST_SETTLE;
            scnt  <= SW'(OP_CYCLES - 1);
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_XFER: begin
          if (at_last) state <= ST_IDLE;
          else         cnt   <= cnt + 1'b1;
        end
        ST_SETTLE: begin
          if (scnt == '0) state <= ST_IDLE;
          else            scnt  <= scnt - 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy      = (state != ST_IDLE);
  assign buf_lock  = busy && uses_buf;
  assign arr_we    = (state == ST_ERASE) || (state == ST_PROG);
  assign arr_addr  = base + AW'(cnt);
  assign arr_wdata = (state == ST_ERASE) ? 8'hFF : buf_rdata;
  assign buf_we    = (state == ST_XFER);
  assign buf_idx   = BW'(cnt);
  assign buf_wdata = arr_rdata;
  assign ev_done   = ((state == ST_SETTLE) && (scnt == '0)) ||
                     ((state == ST_XFER) && at_last);

endmodule

// File: rtl/dbuf_flash_seq.sv
module dbuf_flash_seq
  import fsq_pkg::*;
#(
  parameter int PAGES      = 16,
  parameter int PAGE_BYTES = 264,
  parameter int BLK_PAGES  = 8,
  parameter int OP_CYCLES  = 16,
  localparam int PW        = $clog2(PAGES),
  localparam int BW        = $clog2(PAGE_BYTES),
  localparam int DEPTH     = PAGES * PAGE_BYTES,
  localparam int AW        = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [3:0]    cmd_op,
  input  logic          cmd_buf,
  input  logic [PW-1:0] cmd_page,
  input  logic [BW-1:0] cmd_byte,
  input  logic [7:0]    cmd_wdata,
  input  logic          write_protect,
  output logic          ready,
  output logic          cmd_reject,
  output logic          rd_valid,
  output logic [7:0]    rd_data
);

  fsq_op_e op;
  logic    op_known, range_ok, reject, accept, seq_start;
  logic    busy, buf_lock, act_buf, arr_we, buf_we, ev_done;
  logic [AW-1:0] arr_addr, arr_raddr, host_addr;
  logic [7:0]    arr_wdata, arr_rdata, buf_wdata, seq_buf_rdata;
  logic [BW-1:0] buf_idx;
  logic [7:0]    buf_q [2];
  logic [PW-1:0] rd_pg, host_pg;
  logic [BW-1:0] rd_bi, host_bi;

  // ---------------- command decode ----------------
  assign op       = fsq_op_e'(cmd_op);
  assign op_known = (cmd_op <= 4'd8);
  assign range_ok = (32'(cmd_page) < PAGES) && (32'(cmd_byte) < PAGE_BYTES);

  always_comb begin
    reject = 1'b0;
    if (cmd_valid && op != OP_NOP) begin
      if (!op_known)                                        reject = 1'b1;
      if (op != OP_RD_NEXT && !range_ok)                    reject = 1'b1;
      if (busy && needs_idle(op))                           reject = 1'b1;
      if (buf_lock && is_buf_op(op) && cmd_buf == act_buf)  reject = 1'b1;
      if (write_protect && alters_array(op))                reject = 1'b1;
    end
  end

  assign accept    = cmd_valid && (op != OP_NOP) && !reject;
  assign seq_start = accept && (alters_array(op) || op == OP_PG_TO_BUF);

  // ---------------- sequencer ----------------
  fsq_seq #(
    .PAGES(PAGES), .PAGE_BYTES(PAGE_BYTES), .BLK_PAGES(BLK_PAGES),
    .OP_CYCLES(OP_CYCLES), .PW(PW), .BW(BW), .AW(AW)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (seq_start),
    .start_op   (op),
    .start_page (cmd_page),
    .start_buf  (cmd_buf),
    .buf_rdata  (seq_buf_rdata),
    .arr_rdata  (arr_rdata),
    .busy       (busy),
    .buf_lock   (buf_lock),
    .act_buf    (act_buf),
    .arr_we     (arr_we),
    .arr_addr   (arr_addr),
    .arr_wdata  (arr_wdata),
    .buf_we     (buf_we),
    .buf_idx    (buf_idx),
    .buf_wdata  (buf_wdata),
    .ev_done    (ev_done)
  );

  // ---------------- staging buffers ----------------
  for (genvar gi = 0; gi < 2; gi++) begin : g_buf
    logic          mine, seq_wr, host_wr;
    logic [BW-1:0] waddr, raddr;
    logic [7:0]    wdata;

    assign mine    = (act_buf == 1'(gi));
    assign seq_wr  = buf_we && mine;
    assign host_wr = accept && (op == OP_BUF_WR) && (cmd_buf == 1'(gi));
    assign waddr   = seq_wr ? buf_idx : cmd_byte;
    assign wdata   = seq_wr ? buf_wdata : cmd_wdata;
    assign raddr   = (buf_lock && mine) ? buf_idx : cmd_byte;

    fsq_sram #(.DEPTH(PAGE_BYTES), .AW(BW), .INIT(8'hFF)) u_mem (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (seq_wr || host_wr),
      .waddr (waddr),
      .wdata (wdata),
      .raddr (raddr),
      .rdata (buf_q[gi])
    );
  end

  assign seq_buf_rdata = buf_q[act_buf];

  // ---------------- main array ----------------
  assign host_pg   = (op == OP_RD_NEXT) ? rd_pg : cmd_page;
  assign host_bi   = (op == OP_RD_NEXT) ? rd_bi : cmd_byte;
  assign host_addr = AW'(flat_index(32'(host_pg), 32'(host_bi), PAGE_BYTES));
  assign arr_raddr = busy ? arr_addr : host_addr;

  fsq_sram #(.DEPTH(DEPTH), .AW(AW), .INIT(8'hFF)) u_array (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (arr_we),
    .waddr (arr_addr),
    .wdata (arr_wdata),
    .raddr (arr_raddr),
    .rdata (arr_rdata)
  );

  // ---------------- read path and responses ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid   <= 1'b0;
      rd_data    <= 8'h00;
      cmd_reject <= 1'b0;
      rd_pg      <= '0;
      rd_bi      <= '0;
    end else begin
      cmd_reject <= reject;
      rd_valid   <= accept && (op == OP_BUF_RD || op == OP_RD_START ||
                               op == OP_RD_NEXT);
      if (accept && op == OP_BUF_RD) rd_data <= buf_q[cmd_buf];
      else if (accept && (op == OP_RD_START || op == OP_RD_NEXT))
        rd_data <= arr_rdata;
      if (accept && (op == OP_RD_START || op == OP_RD_NEXT)) begin
        rd_pg <= PW'(step_page(32'(host_pg), 32'(host_bi), PAGE_BYTES, PAGES));
        rd_bi <= BW'(step_byte(32'(host_bi), PAGE_BYTES));
      end
    end
  end

  assign ready = !busy;

endmodule

// File: rtl/dbuf_flash_seq_chk.sv
module dbuf_flash_seq_chk #(
  parameter int DEPTH = 4224,
  parameter int AW    = 13
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_valid,
  input logic [3:0]    cmd_op,
  input logic          write_protect,
  input logic          ready,
  input logic          cmd_reject,
  input logic          rd_valid,
  input logic          seq_start,
  input logic          ev_done,
  input logic          arr_we,
  input logic [AW-1:0] arr_addr
);

  AST_START_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    seq_start |=> !ready);  // R6

  AST_DONE_RAISES_READY: assert property (@(posedge clk) disable iff (!rst_n)
    ev_done |=> ready);  // R6

  AST_NO_WRITE_WHEN_READY: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> !arr_we);  // R6

  AST_PROTECT_REJECTS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && write_protect && cmd_op >= 4'd3 && cmd_op <= 4'd5)
      |=> cmd_reject);  // R9

  AST_BUSY_REJECTS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !ready && cmd_op >= 4'd3 && cmd_op <= 4'd8)
      |=> cmd_reject);  // R10

  AST_WRITE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> (32'(arr_addr) < DEPTH));  // R1

  AST_READ_XOR_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_valid && cmd_reject));  // R2

endmodule

bind dbuf_flash_seq dbuf_flash_seq_chk #(.DEPTH(DEPTH), .AW(AW)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cmd_valid     (cmd_valid),
  .cmd_op        (cmd_op),
  .write_protect (write_protect),
  .ready         (ready),
  .cmd_reject    (cmd_reject),
  .rd_valid      (rd_valid),
  .seq_start     (seq_start),
  .ev_done       (ev_done),
  .arr_we        (arr_we),
  .arr_addr      (arr_addr)
);

// File: tb/dbuf_flash_seq_bench.sv
module dbuf_flash_seq_bench;

  localparam int PAGES = 16;
  localparam int PB    = 264;
  localparam int GRP   = 8;
  localparam int OPC   = 20;
  localparam int PW    = $clog2(PAGES);
  localparam int BW    = $clog2(PB);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic [3:0]    cmd_op = '0;
  logic          cmd_buf = 1'b0;
  logic [PW-1:0] cmd_page = '0;
  logic [BW-1:0] cmd_byte = '0;
  logic [7:0]    cmd_wdata = '0;
  logic          write_protect = 1'b0;
  logic          ready, cmd_reject, rd_valid;
  logic [7:0]    rd_data;

  always #10 clk = ~clk;

  dbuf_flash_seq #(.PAGES(PAGES), .PAGE_BYTES(PB), .BLK_PAGES(GRP),
                   .OP_CYCLES(OPC)) u_dbuf_flash_seq (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_buf(cmd_buf), .cmd_page(cmd_page), .cmd_byte(cmd_byte),
    .cmd_wdata(cmd_wdata), .write_protect(write_protect), .ready(ready),
    .cmd_reject(cmd_reject), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int t_acc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // reference model
  logic [7:0] m_arr [PAGES*PB];
  logic [7:0] m_buf [2][PB];
  int m_pg = 0, m_bi = 0;
  logic [7:0] exp_q [$];
  string      tag_q [$];

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R2: actual unexpected read %0h expected none", rd_data);
      end else begin
        chk(tag_q.pop_front(), int'(rd_data), int'(exp_q.pop_front()));
      end
    end
  end

  function automatic logic [7:0] pat(int i, int seed);
    return 8'((i * 7 + seed) & 8'hFF);
  endfunction

  task automatic advance_ptr();
    if (m_bi == PB - 1) begin
      m_bi = 0;
      m_pg = (m_pg == PAGES - 1) ? 0 : m_pg + 1;
    end else m_bi++;
  endtask

  task automatic cmd(input int op, input int b, input int pg, input int bi,
                     input logic [7:0] wd, input bit rej, input string tag);
    cmd_valid = 1'b1; cmd_op = 4'(op); cmd_buf = 1'(b);
    cmd_page = PW'(pg); cmd_byte = BW'(bi); cmd_wdata = wd;
    if (!rej) begin
      case (op)
        1: m_buf[b][bi] = wd;
        2: begin exp_q.push_back(m_buf[b][bi]); tag_q.push_back(tag); end
        3: for (int i = 0; i < PB; i++) m_arr[pg*PB+i] = m_buf[b][i];
        4: for (int i = 0; i < PB; i++) m_arr[pg*PB+i] = 8'hFF;
        5: for (int i = 0; i < GRP*PB; i++) m_arr[(pg/GRP)*GRP*PB+i] = 8'hFF;
        6: for (int i = 0; i < PB; i++) m_buf[b][i] = m_arr[pg*PB+i];
        7: begin
          exp_q.push_back(m_arr[pg*PB+bi]); tag_q.push_back(tag);
          m_pg = pg; m_bi = bi; advance_ptr();
        end
        8: begin
          exp_q.push_back(m_arr[m_pg*PB+m_bi]); tag_q.push_back(tag);
          advance_ptr();
        end
        default: ;
      endcase
    end
    @(posedge clk);
    #1 cmd_valid = 1'b0;
    @(negedge clk);
    t_acc = cyc;
    chk({tag, " reject"}, int'(cmd_reject), int'(rej));
  endtask

  task automatic wait_ready(string tag, int exp_dur);
    while (!ready) @(negedge clk);
    if (exp_dur >= 0) chk({tag, " busy length"}, cyc - t_acc, exp_dur);
  endtask

  task automatic read_page(int pg, string tag);
    cmd(7, 0, pg, 0, 8'h00, 1'b0, tag);
    for (int i = 1; i < PB; i++) cmd(8, 0, 0, 0, 8'h00, 1'b0, tag);
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R6 watchdog: actual no completion expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < PAGES*PB; i++) m_arr[i] = 8'hFF;
    for (int i = 0; i < PB; i++) begin m_buf[0][i] = 8'hFF; m_buf[1][i] = 8'hFF; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 reset state
    chk("R11 ready", int'(ready), 1);
    chk("R11 rd_valid", int'(rd_valid), 0);
    chk("R11 cmd_reject", int'(cmd_reject), 0);
    cmd(2, 0, 0, 5, 8'h00, 1'b0, "R11");
    cmd(2, 1, 0, 263, 8'h00, 1'b0, "R11");
    cmd(7, 0, 3, 10, 8'h00, 1'b0, "R11");

    // R2 buffer fill and readback
    for (int i = 0; i < PB; i++) cmd(1, 0, 0, i, pat(i, 3), 1'b0, "R2");
    cmd(2, 0, 0, 0, 8'h00, 1'b0, "R2");
    cmd(2, 0, 0, 263, 8'h00, 1'b0, "R2");
    cmd(2, 1, 0, 0, 8'h00, 1'b0, "R2");

    // R1 index bounds
    cmd(1, 0, 0, 264, 8'h55, 1'b1, "R1");
    cmd(7, 0, 0, 300, 8'h00, 1'b1, "R1");
    cmd(2, 0, 0, 263, 8'h00, 1'b0, "R1");
    cmd(1, 1, 0, 263, 8'hA5, 1'b0, "R1");
    cmd(11, 0, 0, 0, 8'h00, 1'b1, "R1");

    // R4 and R6: timed program of page 2
    cmd(3, 0, 2, 0, 8'h00, 1'b0, "R4");
    chk("R6 ready low", int'(ready), 0);
    wait_ready("R6", 2*PB + OPC);
    read_page(2, "R4");
    cmd(7, 0, 1, 263, 8'h00, 1'b0, "R4");
    cmd(7, 0, 3, 0, 8'h00, 1'b0, "R4");

    // R3 and R10: ping-pong while page 0 is committed from buffer 0
    cmd(1, 0, 0, 0, 8'h11, 1'b0, "R3");
    cmd(1, 0, 0, 1, 8'h22, 1'b0, "R3");
    cmd(3, 0, 0, 0, 8'h00, 1'b0, "R3");
    cmd(1, 1, 0, 10, 8'h3C, 1'b0, "R3");
    cmd(1, 1, 0, 11, 8'hC3, 1'b0, "R3");
    cmd(2, 1, 0, 10, 8'h00, 1'b0, "R3");
    cmd(1, 0, 0, 5, 8'h00, 1'b1, "R3");
    cmd(2, 0, 0, 5, 8'h00, 1'b1, "R3");
    cmd(3, 1, 5, 0, 8'h00, 1'b1, "R10");
    cmd(4, 0, 5, 0, 8'h00, 1'b1, "R10");
    cmd(5, 0, 8, 0, 8'h00, 1'b1, "R10");
    cmd(6, 1, 5, 0, 8'h00, 1'b1, "R10");
    cmd(7, 0, 2, 0, 8'h00, 1'b1, "R10");
    cmd(8, 0, 0, 0, 8'h00, 1'b1, "R10");
    chk("R10 still busy", int'(ready), 0);
    wait_ready("R3", -1);
    cmd(2, 0, 0, 5, 8'h00, 1'b0, "R3");
    cmd(2, 1, 0, 11, 8'h00, 1'b0, "R3");
    cmd(7, 0, 5, 0, 8'h00, 1'b0, "R10");
    read_page(0, "R3");

    // R4 overwrite of written page without erase command
    cmd(3, 1, 2, 0, 8'h00, 1'b0, "R4");
    wait_ready("R4", 2*PB + OPC);
    read_page(2, "R4");

    // R5 page and block erase
    cmd(3, 0, 7, 0, 8'h00, 1'b0, "R5"); wait_ready("R5", -1);
    cmd(3, 0, 8, 0, 8'h00, 1'b0, "R5"); wait_ready("R5", -1);
    cmd(3, 0, 15, 0, 8'h00, 1'b0, "R5"); wait_ready("R5", -1);
    cmd(4, 0, 7, 0, 8'h00, 1'b0, "R5");
    wait_ready("R6 page erase", PB + OPC);
    cmd(7, 0, 7, 0, 8'h00, 1'b0, "R5");
    cmd(7, 0, 7, 263, 8'h00, 1'b0, "R5");
    cmd(7, 0, 8, 0, 8'h00, 1'b0, "R5");
    cmd(5, 0, 12, 0, 8'h00, 1'b0, "R5");
    wait_ready("R6 block erase", GRP*PB + OPC);
    cmd(7, 0, 8, 0, 8'h00, 1'b0, "R5");
    cmd(7, 0, 15, 263, 8'h00, 1'b0, "R5");
    cmd(7, 0, 0, 0, 8'h00, 1'b0, "R5");
    cmd(7, 0, 2, 10, 8'h00, 1'b0, "R5");

    // R9 write protect
    write_protect = 1'b1;
    cmd(3, 0, 4, 0, 8'h00, 1'b1, "R9");
    cmd(4, 0, 2, 0, 8'h00, 1'b1, "R9");
    cmd(5, 0, 0, 0, 8'h00, 1'b1, "R9");
    chk("R9 ready", int'(ready), 1);
    cmd(1, 1, 0, 20, 8'h77, 1'b0, "R9");
    cmd(2, 1, 0, 20, 8'h00, 1'b0, "R9");
    cmd(7, 0, 2, 10, 8'h00, 1'b0, "R9");
    cmd(7, 0, 0, 1, 8'h00, 1'b0, "R9");
    write_protect = 1'b0;

    // R7 read-modify-write of page 0 through buffer 1
    cmd(6, 1, 0, 0, 8'h00, 1'b0, "R7");
    wait_ready("R6 transfer", PB);
    cmd(2, 1, 0, 1, 8'h00, 1'b0, "R7");
    cmd(1, 1, 0, 100, 8'h5A, 1'b0, "R7");
    cmd(3, 1, 0, 0, 8'h00, 1'b0, "R7");
    wait_ready("R7", -1);
    read_page(0, "R7");

    // R8 continuous read across a page edge and the array end
    cmd(3, 0, 3, 0, 8'h00, 1'b0, "R8"); wait_ready("R8", -1);
    cmd(3, 0, 15, 0, 8'h00, 1'b0, "R8"); wait_ready("R8", -1);
    cmd(7, 0, 2, 262, 8'h00, 1'b0, "R8");
    for (int i = 0; i < 3; i++) cmd(8, 0, 0, 0, 8'h00, 1'b0, "R8");
    cmd(7, 0, 15, 262, 8'h00, 1'b0, "R8");
    for (int i = 0; i < 3; i++) cmd(8, 0, 0, 0, 8'h00, 1'b0, "R8");

    repeat (2) @(negedge clk);
    chk("R2 pending reads", exp_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule